// File: doc/BRIEF.md
# Counted Shift and Rotate Unit with Carry

This unit is the shift and rotate stage of a small processor's execute path. Each operation names an operand, a repeat count from 0 to 7 and the incoming carry flag. The unit applies a single-bit step to the operand as many times as the count says, and it moves the carry at every step. It covers plain byte rotates, byte rotates through carry, logical shifts on a byte and on a 16-bit word, and two digit rotates. A digit rotate moves three 4-bit fields at once: the low nibble of an accumulator byte and the two nibbles of a memory byte.

The caller presents one operation per cycle by raising `in_valid`. One clock edge later the result, the new accumulator and memory bytes and the updated zero, auxiliary-carry and carry flags appear on registered outputs, together with `out_valid`. Register file access, decode and memory addressing belong to the surrounding datapath.

Operation codes on `in_op`: 0 rotate byte right, 1 rotate byte left, 2 rotate byte right through carry, 3 rotate byte left through carry, 4 shift byte right, 5 shift byte left, 6 shift word right, 7 shift word left, 8 digit rotate right, 9 digit rotate left. Codes 10 to 15 are reserved.

Top module: `shrot_unit`

## Requirements
- R1: The step for the selected operation is applied exactly `in_count` times (0 to 7). A count of 0 returns the operand unchanged and leaves the carry equal to `in_cy`.
- R2: Code 0 moves bit 0 into both the carry and bit 7 at each step. Code 1 moves bit 7 into both the carry and bit 0 at each step.
- R3: Code 2 puts bit 0 into the carry and the previous carry into bit 7 at each step. Code 3 puts bit 7 into the carry and the previous carry into bit 0 at each step. Each is a 9-bit rotation.
- R4: Code 4 shifts the byte right, filling bit 7 with 0 and carrying out bit 0. Code 5 shifts it left, filling bit 0 with 0 and carrying out bit 7. For codes 0 to 5, `out_res[15:8]` is 0.
- R5: Code 6 shifts the 16-bit word right, filling bit 15 with 0 and carrying out bit 0. Code 7 shifts it left, filling bit 0 with 0 and carrying out bit 15.
- R6: For codes 4 to 7, the zero flag is set exactly when the result (8 bits for codes 4 and 5, 16 bits for codes 6 and 7) is all zeros. The auxiliary carry is cleared, and the carry holds the last bit shifted out.
- R7: For codes 0 to 3, the zero and auxiliary-carry outputs equal `in_z` and `in_ac`. Only the carry is changed.
- R8: Code 8 gives acc[3:0] = mem[3:0], mem[7:4] = old acc[3:0] and mem[3:0] = old mem[7:4]. Code 9 gives acc[3:0] = mem[7:4], mem[3:0] = old acc[3:0] and mem[7:4] = old mem[3:0]. For both codes `out_res` is 0.
- R9: Codes 8 and 9 keep acc[7:4] and copy all three flags from their inputs. The count has no effect on them.
- R10: For codes 10 to 15, `out_res` equals the operand, the accumulator and memory bytes pass through unchanged, and all flags equal their inputs. For codes 0 to 7, `out_acc` and `out_mem` equal `in_acc` and `in_mem`.
- R11: Outputs are registered. Values from an operation with `in_valid` high appear after the next rising clock edge, and `out_valid` then follows `in_valid`. While `in_valid` is low, all data and flag outputs hold their values.
- R12: A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 4 | Operation code |
| in_opnd | input | 16 | Operand; low byte for byte operations |
| in_count | input | 3 | Repeat count 0 to 7 |
| in_cy | input | 1 | Carry flag in |
| in_z | input | 1 | Zero flag in |
| in_ac | input | 1 | Auxiliary-carry flag in |
| in_acc | input | 8 | Accumulator byte for digit rotates |
| in_mem | input | 8 | Memory byte for digit rotates |
| out_valid | output | 1 | Outputs carry a new result |
| out_res | output | 16 | Shift or rotate result |
| out_acc | output | 8 | Accumulator byte after the operation |
| out_mem | output | 8 | Memory byte after the operation |
| out_z | output | 1 | Zero flag out |
| out_ac | output | 1 | Auxiliary-carry flag out |
| out_cy | output | 1 | Carry flag out |

## Verification
Every output is due exactly one rising edge after the edge that samples `in_valid` high. This applies to the result, both bytes, all three flags and `out_valid`, because the whole counted chain settles within one cycle. The bench drives each operation on a falling edge and compares on the next falling edge, which is half a period after the capturing edge. It then holds `in_valid` low with new data for one more cycle and confirms that the outputs have not moved. Reset is checked the same way, one edge after `rst_n` has been sampled low.

// File: rtl/shrot_pkg.sv
// Shared operation codes and operation-class helpers for the counted
// shift and rotate unit. Assumes a 4-bit operation code.
package shrot_pkg;

    localparam logic [3:0] OP_ROR_B  = 4'd0;
    localparam logic [3:0] OP_ROL_B  = 4'd1;
    localparam logic [3:0] OP_RORC_B = 4'd2;
    localparam logic [3:0] OP_ROLC_B = 4'd3;
    localparam logic [3:0] OP_SHR_B  = 4'd4;
    localparam logic [3:0] OP_SHL_B  = 4'd5;
    localparam logic [3:0] OP_SHR_W  = 4'd6;
    localparam logic [3:0] OP_SHL_W  = 4'd7;
    localparam logic [3:0] OP_DIG_R  = 4'd8;
    localparam logic [3:0] OP_DIG_L  = 4'd9;

    // Byte rotates, plain or through carry.
    function automatic logic op_is_rot(input logic [3:0] op);
        return op <= OP_ROLC_B;
    endfunction

    // Logical shifts of byte or word.
    function automatic logic op_is_shift(input logic [3:0] op);
        return (op >= OP_SHR_B) && (op <= OP_SHL_W);
    endfunction

    // Operations that act on the low byte only.
    function automatic logic op_is_byte(input logic [3:0] op);
        return op <= OP_SHL_B;
    endfunction

    // Word shifts.
    function automatic logic op_is_word(input logic [3:0] op);
        return (op == OP_SHR_W) || (op == OP_SHL_W);
    endfunction

    // Nibble rotates between accumulator and memory byte.
    function automatic logic op_is_digit(input logic [3:0] op);
        return (op == OP_DIG_R) || (op == OP_DIG_L);
    endfunction

endpackage

// File: rtl/shrot_step.sv
// One single-bit step of a shift or rotate, carry included.
// Assumes: for byte operations the upper part of cur_val is zero.
// Codes outside the shift/rotate set pass value and carry unchanged.
module shrot_step
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] cur_val,
    input  logic              cur_cy,
    output logic [DATA_W-1:0] nxt_val,
    output logic              nxt_cy
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [BYTE_W-1:0] lo;
    assign lo = cur_val[BYTE_W-1:0];

    // Select the next value and carry for one bit of movement.
    always_comb begin
        nxt_val = cur_val;
        nxt_cy  = cur_cy;
        case (op)
            OP_ROR_B: begin
                nxt_val = {{HI_W{1'b0}}, lo[0], lo[BYTE_W-1:1]};
                nxt_cy  = lo[0];
            end
            OP_ROL_B: begin
                nxt_val = {{HI_W{1'b0}}, lo[BYTE_W-2:0], lo[BYTE_W-1]};
                nxt_cy  = lo[BYTE_W-1];
            end
            OP_RORC_B: begin
                nxt_val = {{HI_W{1'b0}}, cur_cy, lo[BYTE_W-1:1]};
                nxt_cy  = lo[0];
            end
            OP_ROLC_B: begin
                nxt_val = {{HI_W{1'b0}}, lo[BYTE_W-2:0], cur_cy};
                nxt_cy  = lo[BYTE_W-1];
            end
            OP_SHR_B: begin
                nxt_val = {{HI_W{1'b0}}, 1'b0, lo[BYTE_W-1:1]};
                nxt_cy  = lo[0];
            end
            OP_SHL_B: begin
                nxt_val = {{HI_W{1'b0}}, lo[BYTE_W-2:0], 1'b0};
                nxt_cy  = lo[BYTE_W-1];
            end
            OP_SHR_W: begin
                nxt_val = {1'b0, cur_val[DATA_W-1:1]};
                nxt_cy  = cur_val[0];
            end
            OP_SHL_W: begin
                nxt_val = {cur_val[DATA_W-2:0], 1'b0};
                nxt_cy  = cur_val[DATA_W-1];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/shrot_chain.sv
// Unrolled chain of single-bit steps; the tap selected by count gives
// the result after count repetitions. Assumes count <= 2**CNT_W - 1.
module shrot_chain
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] src_val,
    input  logic              src_cy,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] dst_val,
    output logic              dst_cy
);
    localparam int STEPS = (1 << CNT_W) - 1;
    localparam int HI_W  = DATA_W - BYTE_W;

    logic [DATA_W-1:0] stage_val [STEPS+1];
    logic              stage_cy  [STEPS+1];

    // Byte operations see a zero-extended low byte.
    assign stage_val[0] = op_is_byte(op) ? {{HI_W{1'b0}}, src_val[BYTE_W-1:0]}
                                         : src_val;
    assign stage_cy[0]  = src_cy;

    generate
        for (genvar g = 0; g < STEPS; g++) begin : g_step
            shrot_step #(
                .DATA_W(DATA_W),
                .BYTE_W(BYTE_W)
            ) u_step (
                .op      (op),
                .cur_val (stage_val[g]),
                .cur_cy  (stage_cy[g]),
                .nxt_val (stage_val[g+1]),
                .nxt_cy  (stage_cy[g+1])
            );
        end
    endgenerate

    // Tap the stage matching the repeat count.
    assign dst_val = stage_val[count];
    assign dst_cy  = stage_cy[count];

endmodule

// File: rtl/shrot_digit.sv
// Three-way nibble exchange between the accumulator low nibble and the
// two nibbles of a memory byte. The accumulator high nibble is kept.
module shrot_digit #(
    parameter int BYTE_W = 8
) (
    input  logic              to_left,
    input  logic [BYTE_W-1:0] acc_in,
    input  logic [BYTE_W-1:0] mem_in,
    output logic [BYTE_W-1:0] acc_out,
    output logic [BYTE_W-1:0] mem_out
);
    localparam int NIB_W = BYTE_W / 2;

    logic [NIB_W-1:0] a_lo, a_hi, m_lo, m_hi;
    assign a_lo = acc_in[NIB_W-1:0];
    assign a_hi = acc_in[BYTE_W-1:NIB_W];
    assign m_lo = mem_in[NIB_W-1:0];
    assign m_hi = mem_in[BYTE_W-1:NIB_W];

    // Route the three nibbles according to direction.
    always_comb begin
        if (to_left) begin
            acc_out = {a_hi, m_hi};
            mem_out = {m_lo, a_lo};
        end else begin
            acc_out = {a_hi, m_lo};
            mem_out = {a_lo, m_hi};
        end
    end

endmodule

// File: rtl/shrot_flags.sv
// Flag update: shifts set Z from the result width, clear AC and take the
// chain carry; rotates take only the chain carry; others pass flags through.
module shrot_flags
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] res,
    input  logic              chain_cy,
    input  logic              z_in,
    input  logic              ac_in,
    input  logic              cy_in,
    output logic              z_out,
    output logic              ac_out,
    output logic              cy_out
);
    // Pick the flag sources by operation class.
    always_comb begin
        z_out  = z_in;
        ac_out = ac_in;
        cy_out = cy_in;
        if (op_is_shift(op)) begin
            z_out  = op_is_word(op) ? (res == '0) : (res[BYTE_W-1:0] == '0);
            ac_out = 1'b0;
            cy_out = chain_cy;
        end else if (op_is_rot(op)) begin
            cy_out = chain_cy;
        end
    end

endmodule

// File: rtl/shrot_unit.sv
// Counted shift/rotate unit with carry. Accepts one operation per cycle
// when in_valid is high and presents registered results one edge later.
// Assumes the caller holds no state; outputs keep their value when idle.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic [DATA_W-1:0] in_opnd,
    input  logic [CNT_W-1:0]  in_count,
    input  logic              in_cy,
    input  logic              in_z,
    input  logic              in_ac,
    input  logic [BYTE_W-1:0] in_acc,
    input  logic [BYTE_W-1:0] in_mem,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res,
    output logic [BYTE_W-1:0] out_acc,
    output logic [BYTE_W-1:0] out_mem,
    output logic              out_z,
    output logic              out_ac,
    output logic              out_cy
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] chain_val;
    logic              chain_cy;
    logic [BYTE_W-1:0] dig_acc, dig_mem;
    logic [DATA_W-1:0] res_next;
    logic [BYTE_W-1:0] acc_next, mem_next;
    logic              z_next, ac_next, cy_next;
    logic              is_digit;

    assign is_digit = op_is_digit(in_op);

    shrot_chain #(
        .DATA_W(DATA_W),
        .BYTE_W(BYTE_W),
        .CNT_W (CNT_W)
    ) u_chain (
        .op      (in_op),
        .src_val (in_opnd),
        .src_cy  (in_cy),
        .count   (in_count),
        .dst_val (chain_val),
        .dst_cy  (chain_cy)
    );

    shrot_digit #(
        .BYTE_W(BYTE_W)
    ) u_digit (
        .to_left (in_op == OP_DIG_L),
        .acc_in  (in_acc),
        .mem_in  (in_mem),
        .acc_out (dig_acc),
        .mem_out (dig_mem)
    );

    shrot_flags #(
        .DATA_W(DATA_W),
        .BYTE_W(BYTE_W)
    ) u_flags (
        .op       (in_op),
        .res      (chain_val),
        .chain_cy (chain_cy),
        .z_in     (in_z),
        .ac_in    (in_ac),
        .cy_in    (in_cy),
        .z_out    (z_next),
        .ac_out   (ac_next),
        .cy_out   (cy_next)
    );

    // Merge digit and chain results into the next output values.
    always_comb begin
        res_next = is_digit ? '0 : chain_val;
        acc_next = is_digit ? dig_acc : in_acc;
        mem_next = is_digit ? dig_mem : in_mem;
    end

    // Output registers: clear on reset, load on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_acc   <= '0;
            out_mem   <= '0;
            out_z     <= 1'b0;
            out_ac    <= 1'b0;
            out_cy    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res <= res_next;
                out_acc <= acc_next;
                out_mem <= mem_next;
                out_z   <= z_next;
                out_ac  <= ac_next;
                out_cy  <= cy_next;
            end
        end
    end

    // R11: a valid operation yields out_valid on the next edge.
    p_valid_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R11: idle cycles hold results and drop out_valid.
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_res) && $stable(out_acc)
                       && $stable(out_mem) && $stable(out_cy)));

    // R1: count of zero keeps the carry for every operation.
    p_zero_count_cy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_count == '0) |=> (out_cy == $past(in_cy)));

    // R6: shifts always clear the auxiliary carry.
    p_shift_ac_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_shift(in_op)) |=> !out_ac);

    // R7: rotates keep zero and auxiliary carry.
    p_rot_flags_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_rot(in_op)) |=>
            (out_z == $past(in_z) && out_ac == $past(in_ac)));

    // R9: digit rotates keep all flags and the accumulator high nibble.
    p_digit_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_digit(in_op)) |=>
            (out_z == $past(in_z) && out_ac == $past(in_ac) && out_cy == $past(in_cy)
             && out_acc[BYTE_W-1:BYTE_W/2] == $past(in_acc[BYTE_W-1:BYTE_W/2])));

    // R4: byte operations produce a zero upper result part.
    p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_byte(in_op)) |=> (out_res[DATA_W-1:BYTE_W] == {HI_W{1'b0}}));

endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [3:0]  in_op;
    logic [15:0] in_opnd;
    logic [2:0]  in_count;
    logic        in_cy, in_z, in_ac;
    logic [7:0]  in_acc, in_mem;
    logic        out_valid;
    logic [15:0] out_res;
    logic [7:0]  out_acc, out_mem;
    logic        out_z, out_ac, out_cy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    shrot_unit u_shrot_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_opnd(in_opnd), .in_count(in_count), .in_cy(in_cy), .in_z(in_z),
        .in_ac(in_ac), .in_acc(in_acc), .in_mem(in_mem), .out_valid(out_valid),
        .out_res(out_res), .out_acc(out_acc), .out_mem(out_mem),
        .out_z(out_z), .out_ac(out_ac), .out_cy(out_cy)
    );

    // Bit-by-bit reference: returns {res16, acc8, mem8, z, ac, cy}.
    function automatic logic [34:0] ref_calc(input logic [3:0] op, input logic [15:0] opnd,
            input int cnt, input logic cy_i, input logic z_i, input logic ac_i,
            input logic [7:0] acc, input logic [7:0] mem);
        logic [15:0] v = opnd;
        logic c = cy_i, z = z_i, ac = ac_i, b;
        logic [7:0] a = acc, m = mem;
        if (op <= 4'd7) begin
            if (op <= 4'd5) v[15:8] = 8'h00;
            for (int k = 0; k < cnt; k++) begin
                case (op)
                    4'd0: begin c = v[0]; v[7:0] = {c, v[7:1]}; end
                    4'd1: begin c = v[7]; v[7:0] = {v[6:0], c}; end
                    4'd2: begin b = v[0]; v[7:0] = {c, v[7:1]}; c = b; end
                    4'd3: begin b = v[7]; v[7:0] = {v[6:0], c}; c = b; end
                    4'd4: begin c = v[0]; v[7:0] = v[7:0] >> 1; end
                    4'd5: begin c = v[7]; v[7:0] = v[7:0] << 1; end
                    4'd6: begin c = v[0]; v = v >> 1; end
                    default: begin c = v[15]; v = v << 1; end
                endcase
            end
            if (op >= 4'd4) begin
                ac = 1'b0;
                z = (op <= 4'd5) ? (v[7:0] == 8'h00) : (v == 16'h0000);
            end
        end else if (op == 4'd8) begin
            a = {acc[7:4], mem[3:0]};
            m = {acc[3:0], mem[7:4]};
            v = 16'h0000;
        end else if (op == 4'd9) begin
            a = {acc[7:4], mem[7:4]};
            m = {mem[3:0], acc[3:0]};
            v = 16'h0000;
        end
        return {v, a, m, z, ac, c};
    endfunction

    function automatic string data_tag(input logic [3:0] op, input int cnt);
        if (op >= 4'd10) return "R10";
        if (op >= 4'd8)  return "R8";
        if (cnt == 0)    return "R1";
        if (op <= 4'd1)  return "R2";
        if (op <= 4'd3)  return "R3";
        if (op <= 4'd5)  return "R4";
        return "R5";
    endfunction

    function automatic string flag_tag(input logic [3:0] op);
        if (op >= 4'd10) return "R10";
        if (op >= 4'd8)  return "R9";
        if (op >= 4'd4)  return "R6";
        return "R7";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] got,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one operation, then compare on the falling edge after capture.
    task automatic run_vec(input logic [3:0] op, input logic [15:0] opnd, input int cnt,
            input logic cy_i, input logic z_i, input logic ac_i,
            input logic [7:0] acc, input logic [7:0] mem, input bit hold_chk);
        logic [34:0] exp;
        logic [34:0] got;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_opnd = opnd; in_count = 3'(cnt);
        in_cy = cy_i; in_z = z_i; in_ac = ac_i; in_acc = acc; in_mem = mem;
        exp = ref_calc(op, opnd, cnt, cy_i, z_i, ac_i, acc, mem);
        @(negedge clk);
        in_valid = 1'b0;
        got = {out_res, out_acc, out_mem, out_z, out_ac, out_cy};
        check(got[34:3] == exp[34:3], data_tag(op, cnt), 64'(got[34:3]), 64'(exp[34:3]));
        check(got[2:0] == exp[2:0], flag_tag(op), 64'(got[2:0]), 64'(exp[2:0]));
        check(out_valid == 1'b1, "R11", 64'(out_valid), 64'd1);
        if (hold_chk) begin
            // R11: new data with in_valid low must not reach the outputs.
            in_op = 4'(~op); in_opnd = ~opnd; in_cy = ~cy_i; in_acc = ~acc; in_mem = ~mem;
            @(negedge clk);
            check({out_valid, out_res, out_acc, out_mem, out_z, out_ac, out_cy} ==
                  {1'b0, exp}, "R11", 64'({out_valid, out_res, out_acc, out_mem,
                  out_z, out_ac, out_cy}), 64'({1'b0, exp}));
        end
    endtask

    // R12: every output is zero one edge after reset is sampled low.
    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; in_op = 4'd7; in_opnd = 16'hFFFF;
        in_count = 3'd1; in_cy = 1'b1; in_z = 1'b1; in_ac = 1'b1;
        in_acc = 8'hFF; in_mem = 8'hFF;
        @(negedge clk);
        check({out_valid, out_res, out_acc, out_mem, out_z, out_ac, out_cy} == '0,
              "R12", 64'({out_valid, out_res, out_acc, out_mem, out_z, out_ac, out_cy}),
              64'd0);
        rst_n = 1'b1; in_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_opnd = '0; in_count = '0;
        in_cy = 1'b0; in_z = 1'b0; in_ac = 1'b0; in_acc = '0; in_mem = '0;
        repeat (3) @(negedge clk);
        reset_check();

        // Directed corners: R6 word shift to zero, R5 carry from bit 15, R3 carry into bit 0.
        run_vec(4'd7, 16'h8000, 1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
        run_vec(4'd6, 16'h0001, 1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
        run_vec(4'd3, 16'h0000, 7, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
        run_vec(4'd4, 16'hFF80, 7, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
        // R8 and R9 digit rotates with distinct nibbles.
        run_vec(4'd8, 16'h1234, 5, 1'b1, 1'b0, 1'b1, 8'hAB, 8'hCD, 1'b1);
        run_vec(4'd9, 16'h1234, 0, 1'b0, 1'b1, 1'b0, 8'hAB, 8'hCD, 1'b1);

        // Sweep of every code, count and carry-in (R1 to R10).
        for (int op = 0; op < 16; op++) begin
            for (int cnt = 0; cnt < 8; cnt++) begin
                for (int c = 0; c < 2; c++) begin
                    run_vec(4'(op), 16'hA5C3, cnt, 1'(c), 1'(cnt & 1), 1'(op & 1),
                            8'h5E, 8'h93, 1'b0);
                    run_vec(4'(op), 16'h8001, cnt, 1'(c), 1'b1, 1'b1, 8'h0F, 8'hF0, 1'b0);
                end
            end
        end

        // Constrained random operations across all codes.
        for (int i = 0; i < 1500; i++) begin
            run_vec(4'($urandom_range(15)), 16'($urandom), int'($urandom_range(7)),
                    1'($urandom), 1'($urandom), 1'($urandom),
                    8'($urandom), 8'($urandom), (i % 8) == 0);
        end

        reset_check();
        run_vec(4'd0, 16'h0081, 1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11: watchdog expired got %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule